// File: doc/BRIEF.md
# Flash Read Responder

This block forms the value returned on every read of a parallel NOR flash model. A separate write sequencer tracks the unlock and command cycles and reports the active command code. From that code, this block decides what a read returns. It can return array bytes, identification words, the busy/done status byte, or a byte from the query table. It also owns the status byte. The sequencer's program, erase-start and erase-done pulses update that byte. Each status read flips bit 6, so software can poll until two reads in a row agree.

The array contents and the query table live outside the block. They are reached through two combinational lookup ports. The array port returns four consecutive bytes starting at the byte address presented. The table port returns one byte for the word offset presented. A read is a one-cycle strobe. Its result is registered and appears one clock later together with a valid flag. A command code the block does not recognise is served as a plain array read. In that case a one-cycle resync pulse is raised so the sequencer can return to idle.

Top module: `flash_read_responder`

## Requirements
- R1: `rdValid` is high exactly in the cycle after a cycle with `rdStb` high. `rdData` changes only in the cycle after a strobe and otherwise holds its value.
- R2: With command code 0x00 or 0x80, a read returns array bytes. Let b0..b3 be the bytes at addresses A..A+3. `rdSize` 0 gives {24'h0,b0}. `rdSize` 1 gives {16'h0,b0,b1} when `bigEnd`=1 and {16'h0,b1,b0} otherwise. `rdSize` 2 or 3 gives {b0,b1,b2,b3} when `bigEnd`=1 and {b3,b2,b1,b0} otherwise.
- R3: With command code 0x90, word offsets 0 and 1 return `ID0` and `ID1`, and offset 2 returns 0. All values are zero-extended to 32 bits.
- R4: With command code 0x90, offset 0x0E returns `ID2` and offset 0x0F returns `ID3`. If that parameter is all ones, the read returns array data as in R2. Every other offset also returns array data.
- R5: With command code 0xA0, 0x10 or 0x30, a read returns the status byte as it was before the read, zero-extended. Bit 6 of the status is inverted by each such read. Reads under any other code leave the status unchanged.
- R6: A `progStb` pulse sets the status to {~progMsb, 7'h7F}.
- R7: An `eraseStartStb` pulse without `progStb` clears the status to 0x00. An `eraseDoneStb` pulse inverts status bit 7 on top of any same-cycle load. A status read's bit-6 flip applies last.
- R8: With command code 0x98, a read returns `cfiByte` for the word offset when that offset is below `CFI_LEN`, and 0 otherwise. `cfiIdx` always carries the word offset.
- R9: The word offset is `rdAddr[7:0]` shifted right by 0, 1 or 2 for `DEV_BYTES` of 1, 2 or 4. Address bits above bit 7 do not affect it.
- R10: A read under any other command code returns array data as in R2. It also drives `resyncStb` high for exactly the cycle in which that data is valid.
- R11: After reset, `rdData` is 0, `rdValid` and `resyncStb` are low, and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStb | input | 1 | One-cycle read request |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdSize | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bigEnd | input | 1 | 1 = assemble bytes big-endian |
| cmdCode | input | 8 | Active command code from the write sequencer |
| progStb | input | 1 | Program completed; loads status from progMsb |
| progMsb | input | 1 | Bit 7 of the programmed data |
| eraseStartStb | input | 1 | Erase started; clears status |
| eraseDoneStb | input | 1 | Erase finished; flips status bit 7 |
| arrAddr | output | ADDR_W | Byte address into the array lookup |
| arrBytes | input | 32 | Bytes at arrAddr+0..+3, byte k in bits 8k+7:8k |
| cfiIdx | output | 8 | Word offset into the query table |
| cfiByte | input | 8 | Query table byte at cfiIdx |
| rdData | output | 32 | Registered read result |
| rdValid | output | 1 | rdData updated this cycle |
| resyncStb | output | 1 | Unknown command seen on a read |

## Verification
The assertions check the following on every cycle:
- the one-cycle read latency and data hold;
- the bit-6 flip on each status read;
- the status loads on program and erase-start;
- the zero returned for query offsets past the table;
- the resync pulse and its alignment with valid data.

Only the bench's scenarios can show the rest. This covers the exact byte order for each size and endianness, and the identification map with its fall-back to array data. It also covers query table passthrough, the erase-done flip of bit 7, and the status value seen across long sequences of mixed reads and updates.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_QUERY  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    load;
    srcSel_e src;
    logic    resync;
  } rdCtl_t;

  localparam logic [7:0] CMD_IDLE         = 8'h00;
  localparam logic [7:0] CMD_ERASE_SETUP  = 8'h80;
  localparam logic [7:0] CMD_AUTOSEL      = 8'h90;
  localparam logic [7:0] CMD_PROGRAM      = 8'hA0;
  localparam logic [7:0] CMD_CHIP_ERASE   = 8'h10;
  localparam logic [7:0] CMD_SECTOR_ERASE = 8'h30;
  localparam logic [7:0] CMD_QUERY        = 8'h98;

  localparam int STAT_W = 8;
  localparam int DATA_W = 32;

endpackage

// File: rtl/flrd_ctrl.sv
module flrd_ctrl
  import flrd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [7:0]        cmdCode,
  input  logic              progStb,
  input  logic              progMsb,
  input  logic              eraseStartStb,
  input  logic              eraseDoneStb,
  output rdCtl_t            ctl,
  output logic [STAT_W-1:0] statusQ
);

  srcSel_e           srcSel;
  logic              cmdKnown;
  logic [STAT_W-1:0] statusD;

  // Map the sequencer's command code onto a read source.
  always_comb begin
    cmdKnown = 1'b1;
    unique case (cmdCode)
      CMD_IDLE, CMD_ERASE_SETUP:                    srcSel = SRC_ARRAY;
      CMD_AUTOSEL:                                  srcSel = SRC_IDENT;
      CMD_PROGRAM, CMD_CHIP_ERASE, CMD_SECTOR_ERASE: srcSel = SRC_STATUS;
      CMD_QUERY:                                    srcSel = SRC_QUERY;
      default: begin
        srcSel   = SRC_ARRAY;
        cmdKnown = 1'b0;
      end
    endcase
  end

  always_comb begin
    ctl.load   = rdStb;
    ctl.src    = srcSel;
    ctl.resync = rdStb && !cmdKnown;
  end

  // Status update order: program load, else erase clear; erase-done flip;
  // poll flip of bit 6 last.
  always_comb begin
    statusD = statusQ;
    if (progStb)            statusD = {~progMsb, 7'h7F};
    else if (eraseStartStb) statusD = '0;
    if (eraseDoneStb)       statusD[7] = ~statusD[7];
    if (rdStb && srcSel == SRC_STATUS) statusD[6] = ~statusD[6];
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

endmodule

// File: rtl/flrd_dpath.sv
module flrd_dpath
  import flrd_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DEV_BYTES = 2,
  parameter logic [15:0] ID0       = 16'h0001,
  parameter logic [15:0] ID1       = 16'h227E,
  parameter logic [15:0] ID2       = 16'h2210,
  parameter logic [15:0] ID3       = 16'hFFFF,
  parameter logic [7:0]  CFI_LEN   = 8'h52
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtl_t            ctl,
  input  logic [STAT_W-1:0] statusQ,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic              bigEnd,
  output logic [ADDR_W-1:0] arrAddr,
  input  logic [31:0]       arrBytes,
  output logic [7:0]        cfiIdx,
  input  logic [7:0]        cfiByte,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              resyncStb
);

  localparam int LANES = 4;
  localparam int SHIFT = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  localparam logic [15:0] ALL_ONES = {16{1'b1}};

  logic [7:0]        lane [LANES];
  logic [7:0]        wordOff;
  logic [DATA_W-1:0] arrWord;
  logic [DATA_W-1:0] idWord;
  logic              idHit;
  logic [DATA_W-1:0] queryWord;
  logic [DATA_W-1:0] dataD;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = arrBytes[8*k +: 8];
  end

  assign wordOff = rdAddr[7:0] >> SHIFT;
  assign arrAddr = rdAddr;
  assign cfiIdx  = wordOff;

  always_comb begin
    unique case (rdSize)
      2'd0:    arrWord = {24'h0, lane[0]};
      2'd1:    arrWord = bigEnd ? {16'h0, lane[0], lane[1]}
                                : {16'h0, lane[1], lane[0]};
      default: arrWord = bigEnd ? {lane[0], lane[1], lane[2], lane[3]}
                                : {lane[3], lane[2], lane[1], lane[0]};
    endcase
  end

  always_comb begin
    idHit  = 1'b1;
    idWord = '0;
    unique case (wordOff)
      8'h00: idWord = {16'h0, ID0};
      8'h01: idWord = {16'h0, ID1};
      8'h02: idWord = '0;
      8'h0E: begin idWord = {16'h0, ID2}; idHit = (ID2 != ALL_ONES); end
      8'h0F: begin idWord = {16'h0, ID3}; idHit = (ID3 != ALL_ONES); end
      default: idHit = 1'b0;
    endcase
  end

  assign queryWord = (wordOff < CFI_LEN) ? {24'h0, cfiByte} : '0;

  always_comb begin
    unique case (ctl.src)
      SRC_IDENT:  dataD = idHit ? idWord : arrWord;
      SRC_STATUS: dataD = {{(DATA_W-STAT_W){1'b0}}, statusQ};
      SRC_QUERY:  dataD = queryWord;
      default:    dataD = arrWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      resyncStb <= 1'b0;
    end else begin
      rdValid   <= ctl.load;
      resyncStb <= ctl.resync;
      if (ctl.load) rdData <= dataD;
    end
  end

endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
  import flrd_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DEV_BYTES = 2,
  parameter logic [15:0] ID0       = 16'h0001,
  parameter logic [15:0] ID1       = 16'h227E,
  parameter logic [15:0] ID2       = 16'h2210,
  parameter logic [15:0] ID3       = 16'hFFFF,
  parameter logic [7:0]  CFI_LEN   = 8'h52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic              bigEnd,
  input  logic [7:0]        cmdCode,
  input  logic              progStb,
  input  logic              progMsb,
  input  logic              eraseStartStb,
  input  logic              eraseDoneStb,
  output logic [ADDR_W-1:0] arrAddr,
  input  logic [31:0]       arrBytes,
  output logic [7:0]        cfiIdx,
  input  logic [7:0]        cfiByte,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              resyncStb
);

  rdCtl_t            ctl;
  logic [STAT_W-1:0] statusQ;

  flrd_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .rdStb         (rdStb),
    .cmdCode       (cmdCode),
    .progStb       (progStb),
    .progMsb       (progMsb),
    .eraseStartStb (eraseStartStb),
    .eraseDoneStb  (eraseDoneStb),
    .ctl           (ctl),
    .statusQ       (statusQ)
  );

  flrd_dpath #(
    .ADDR_W    (ADDR_W),
    .DEV_BYTES (DEV_BYTES),
    .ID0       (ID0),
    .ID1       (ID1),
    .ID2       (ID2),
    .ID3       (ID3),
    .CFI_LEN   (CFI_LEN)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .statusQ   (statusQ),
    .rdAddr    (rdAddr),
    .rdSize    (rdSize),
    .bigEnd    (bigEnd),
    .arrAddr   (arrAddr),
    .arrBytes  (arrBytes),
    .cfiIdx    (cfiIdx),
    .cfiByte   (cfiByte),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .resyncStb (resyncStb)
  );

endmodule

// File: rtl/flrd_checker.sv
module flrd_checker #(
  parameter int         DEV_BYTES = 2,
  parameter logic [7:0] CFI_LEN   = 8'h52
) (
  input logic        clk,
  input logic        rstN,
  input logic        rdStb,
  input logic [7:0]  addrLow,
  input logic [7:0]  cmdCode,
  input logic        progStb,
  input logic        progMsb,
  input logic        eraseStartStb,
  input logic        eraseDoneStb,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic        resyncStb,
  input logic [7:0]  statusQ
);

  localparam int SH = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

  logic [7:0] off;
  logic       statCmd;
  logic       knownCmd;

  assign off      = addrLow >> SH;
  assign statCmd  = (cmdCode == 8'hA0) || (cmdCode == 8'h10) || (cmdCode == 8'h30);
  assign knownCmd = statCmd || (cmdCode == 8'h00) || (cmdCode == 8'h80) ||
                    (cmdCode == 8'h90) || (cmdCode == 8'h98);

  a_r1_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> rdValid);
  a_r1_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> !rdValid);
  a_r1_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));

  a_r5_poll_flips_bit6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && statCmd && !progStb && !eraseStartStb && !eraseDoneStb)
      |=> (statusQ == ($past(statusQ) ^ 8'h40)));
  a_r5_status_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!(rdStb && statCmd) && !progStb && !eraseStartStb && !eraseDoneStb)
      |=> $stable(statusQ));

  a_r6_program_load: assert property (@(posedge clk) disable iff (!rstN)
    (progStb && !eraseDoneStb && !(rdStb && statCmd))
      |=> (statusQ == {~$past(progMsb), 7'h7F}));

  a_r7_erase_clear: assert property (@(posedge clk) disable iff (!rstN)
    (eraseStartStb && !progStb && !eraseDoneStb && !(rdStb && statCmd))
      |=> (statusQ == 8'h00));

  a_r8_query_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && cmdCode == 8'h98 && off >= CFI_LEN) |=> (rdData == 32'h0));

  a_r10_resync_on_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !knownCmd) |=> resyncStb);
  a_r10_resync_only_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && knownCmd) |=> !resyncStb);
  a_r10_resync_with_data: assert property (@(posedge clk) disable iff (!rstN)
    resyncStb |-> rdValid);

endmodule

bind flash_read_responder flrd_checker #(
  .DEV_BYTES (DEV_BYTES),
  .CFI_LEN   (CFI_LEN)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .rdStb         (rdStb),
  .addrLow       (rdAddr[7:0]),
  .cmdCode       (cmdCode),
  .progStb       (progStb),
  .progMsb       (progMsb),
  .eraseStartStb (eraseStartStb),
  .eraseDoneStb  (eraseDoneStb),
  .rdData        (rdData),
  .rdValid       (rdValid),
  .resyncStb     (resyncStb),
  .statusQ       (statusQ)
);

// File: tb/flash_read_responder_tb_top.sv
`timescale 1ns/1ps
module flash_read_responder_tb_top;

  localparam int          AW  = 10;
  localparam int          DB  = 2;
  localparam logic [15:0] I0  = 16'h0001;
  localparam logic [15:0] I1  = 16'h227E;
  localparam logic [15:0] I2  = 16'h2210;
  localparam logic [15:0] I3  = 16'hFFFF;
  localparam logic [7:0]  QL  = 8'h52;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdStb = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [1:0]    rdSize = '0;
  logic          bigEnd = 1'b0;
  logic [7:0]    cmdCode = 8'h00;
  logic          progStb = 1'b0;
  logic          progMsb = 1'b0;
  logic          eraseStartStb = 1'b0;
  logic          eraseDoneStb = 1'b0;
  logic [AW-1:0] arrAddr;
  logic [31:0]   arrBytes;
  logic [7:0]    cfiIdx;
  logic [7:0]    cfiByte;
  logic [31:0]   rdData;
  logic          rdValid;
  logic          resyncStb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] stModel = 8'h00;

  always #4 clk = ~clk;

  function automatic logic [7:0] memByte(input int a);
    return 8'((a * 13) + ((a >> 8) * 5) + 7);
  endfunction

  function automatic logic [7:0] qryByte(input int i);
    return 8'((i * 3) + 17);
  endfunction

  assign arrBytes = {memByte(int'(arrAddr) + 3), memByte(int'(arrAddr) + 2),
                     memByte(int'(arrAddr) + 1), memByte(int'(arrAddr))};
  assign cfiByte  = qryByte(int'(cfiIdx));

  function automatic logic [31:0] expArr(input int a, input int sz, input bit be);
    logic [7:0] b0, b1, b2, b3;
    b0 = memByte(a); b1 = memByte(a + 1); b2 = memByte(a + 2); b3 = memByte(a + 3);
    if (sz == 0) return {24'h0, b0};
    if (sz == 1) return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  flash_read_responder #(
    .ADDR_W (AW), .DEV_BYTES (DB), .ID0 (I0), .ID1 (I1), .ID2 (I2), .ID3 (I3),
    .CFI_LEN (QL)
  ) dut_i (
    .clk (clk), .rstN (rstN), .rdStb (rdStb), .rdAddr (rdAddr), .rdSize (rdSize),
    .bigEnd (bigEnd), .cmdCode (cmdCode), .progStb (progStb), .progMsb (progMsb),
    .eraseStartStb (eraseStartStb), .eraseDoneStb (eraseDoneStb),
    .arrAddr (arrAddr), .arrBytes (arrBytes), .cfiIdx (cfiIdx), .cfiByte (cfiByte),
    .rdData (rdData), .rdValid (rdValid), .resyncStb (resyncStb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe one read; returns at the next falling edge with the result registered.
  task automatic doRead(input int a, input int sz, input bit be);
    @(negedge clk);
    rdAddr = AW'(a); rdSize = 2'(sz); bigEnd = be; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic pulse(input int which, input bit msb);
    @(negedge clk);
    progMsb = msb;
    if (which == 0) progStb = 1'b1;
    if (which == 1) eraseStartStb = 1'b1;
    if (which == 2) eraseDoneStb = 1'b1;
    @(negedge clk);
    progStb = 1'b0; eraseStartStb = 1'b0; eraseDoneStb = 1'b0;
  endtask

  task automatic statusRead(input string req);
    doRead(0, 0, 1'b0);
    check(req, rdData, {24'h0, stModel});
    stModel[6] = ~stModel[6];
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rdData", rdData, 32'h0);
    check("R11 rdValid", {31'h0, rdValid}, 32'h0);
    check("R11 resyncStb", {31'h0, resyncStb}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 latency and hold
    cmdCode = 8'h00;
    doRead(5, 2, 1'b0);
    check("R1 valid after strobe", {31'h0, rdValid}, 32'h1);
    held = rdData;
    @(negedge clk);
    check("R1 valid drops", {31'h0, rdValid}, 32'h0);
    repeat (3) @(negedge clk);
    check("R1 data holds", rdData, held);

    // R2 array reads under both array codes, all sizes and byte orders
    for (int c = 0; c < 2; c++) begin
      cmdCode = (c == 0) ? 8'h00 : 8'h80;
      for (int a = 0; a < 96; a++)
        for (int sz = 0; sz < 4; sz++)
          for (int be = 0; be < 2; be++) begin
            doRead(a * 7, sz, be[0]);
            check("R2 array", rdData, expArr(a * 7, sz, be[0]));
          end
    end

    // R3 R4 R9 identification map
    cmdCode = 8'h90;
    for (int o = 0; o < 128; o++)
      for (int odd = 0; odd < 2; odd++)
        for (int hi = 0; hi < 2; hi++) begin
          int a;
          logic [31:0] e;
          a = hi * 256 + o * 2 + odd;
          e = expArr(a, 1, 1'b0);
          if (o == 0) e = {16'h0, I0};
          else if (o == 1) e = {16'h0, I1};
          else if (o == 2) e = 32'h0;
          else if (o == 14 && I2 != 16'hFFFF) e = {16'h0, I2};
          else if (o == 15 && I3 != 16'hFFFF) e = {16'h0, I3};
          doRead(a, 1, 1'b0);
          if (o < 3) check("R3 ident R9", rdData, e);
          else check("R4 ident/fallback R9", rdData, e);
        end

    // R8 R9 query table
    cmdCode = 8'h98;
    for (int o = 0; o < 128; o++) begin
      doRead(512 + o * 2 + 1, 0, 1'b0);
      check("R8 query R9", rdData, (o < int'(QL)) ? {24'h0, qryByte(o)} : 32'h0);
    end

    // R5 R6 R7 R11 status behaviour
    cmdCode = 8'hA0;
    statusRead("R11 status reset");
    statusRead("R5 toggle");
    statusRead("R5 toggle");
    pulse(0, 1'b1); stModel = 8'h7F;
    statusRead("R6 program msb1");
    statusRead("R5 toggle");
    pulse(0, 1'b0); stModel = 8'hFF;
    statusRead("R6 program msb0");
    cmdCode = 8'h00;
    doRead(3, 0, 1'b0);
    check("R5 array read", rdData, expArr(3, 0, 1'b0));
    cmdCode = 8'hA0;
    statusRead("R5 no toggle on array read");
    cmdCode = 8'h30;
    pulse(1, 1'b0); stModel = 8'h00;
    statusRead("R7 erase clear");
    statusRead("R5 toggle sector");
    pulse(2, 1'b0); stModel[7] = ~stModel[7];
    statusRead("R7 erase done");
    cmdCode = 8'h10;
    pulse(1, 1'b0); stModel = 8'h00;
    statusRead("R7 chip erase clear");
    pulse(2, 1'b0); stModel[7] = ~stModel[7];
    statusRead("R7 chip erase done");
    statusRead("R5 toggle chip");

    // R10 unknown code
    cmdCode = 8'h55;
    doRead(32, 2, 1'b1);
    check("R10 array data", rdData, expArr(32, 2, 1'b1));
    check("R10 resync high", {31'h0, resyncStb}, 32'h1);
    @(negedge clk);
    check("R10 resync pulse ends", {31'h0, resyncStb}, 32'h0);
    cmdCode = 8'hA0;
    doRead(0, 0, 1'b0);
    check("R10 no resync known", {31'h0, resyncStb}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule